// File: doc/BRIEF.md
# Frequency-Trimmed Nanosecond Time-of-Day Counter

This block keeps a 64-bit time-of-day value in nanoseconds. A 32-bit phase accumulator adds a programmable addend once for every edge of the chosen reference. Each time the accumulator wraps, the time value grows by a programmed whole-nanosecond period. The addend is ceil(2^32 / ratio), where the ratio is the reference frequency over the nominal frequency (1000 / period MHz). Changing the addend therefore trims the counter's rate in parts-per-billion steps. The ratio must stay above 1.0, so the accumulator cannot wrap on every edge.

All logic runs on the system clock `clk_sys`. Three asynchronous references (a precision external oscillator, a transmit clock and a real-time-clock input) are each synchronised and edge-detected. The system clock itself is the fourth choice and then counts as an edge on every cycle. A small control state machine has the states OFF, RUN and SETTLE:
- OFF to RUN when the enable is high.
- RUN to OFF when the enable is low.
- Any state to SETTLE on a source write.
- SETTLE to RUN or OFF, according to the enable, once its countdown ends.

Accumulation happens only in RUN.

Top module: `tod_counter_top`

## Requirements
- R1: After reset the time output is 0, the state is OFF and the reference source is the system clock (code 1).
- R2: With the system clock selected and the block running, the accumulator adds the addend on every `clk_sys` cycle.
- R3: A carry out of the 32-bit accumulator is registered as a one-cycle step. The time output grows by `period_ns` at the clock edge after the accumulation that produced the carry.
- R4: When no step is pending and no load is requested, the time output keeps its value.
- R5: A load (`load_en` high at an edge) sets the time output to `load_time` and wins over a step in the same cycle.
- R6: While `run_en` is low (state OFF), no accumulation takes place and the time output only changes by a load. `run_en` sampled high at an edge enters RUN, and the first accumulation follows at the next edge.
- R7: A new addend value is used by the very next accumulation, with no extra delay.
- R8: With an asynchronous reference selected, exactly one accumulation occurs per rising edge of that reference after synchronisation.
- R9: A source write (`src_wr` high at an edge) enters SETTLE for SETTLE_CYC cycles (default 4), during which no accumulation occurs. After that, accumulation resumes if `run_en` is high.
- R10: Source codes on `src_sel`: 0 is the external precision clock, 1 the system clock, 2 the transmit clock, 3 the real-time-clock input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock; also reference code 1 |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_ext | input | 1 | External precision reference (asynchronous) |
| ref_tx | input | 1 | Transmit clock reference (asynchronous) |
| ref_rtc | input | 1 | Real-time-clock reference (asynchronous) |
| src_wr | input | 1 | Strobe that stores `src_sel` |
| src_sel | input | 2 | Reference source code |
| run_en | input | 1 | Enables accumulation |
| addend | input | 32 | Accumulator addend |
| period_ns | input | 16 | Nanoseconds added per carry |
| load_en | input | 1 | Synchronous time load |
| load_time | input | 64 | Value for a load |
| time_ns | output | 64 | Current time in nanoseconds |

## Verification
The bench drives addends that wrap rarely, one that almost always wraps (0xFFFFFFFF) and one that never wraps (0). It also moves the addend while the accumulator is running, so that a design that delayed the addend, or dropped or doubled a carry, would drift away from the cycle-exact scoreboard. Loads are placed on cycles that also carry a step; a design that let the step win, or added both, would show a time off by one period. A source write is checked to freeze the time for exactly the settle window and then resume. Each asynchronous reference runs at a different rate, so a design with a swapped source code would land outside the expected time range for that source.

// File: rtl/tod_pkg.sv
package tod_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_RUN    = 2'd1,
        ST_SETTLE = 2'd2
    } tod_state_e;

    localparam logic [1:0] SRC_EXT = 2'd0;
    localparam logic [1:0] SRC_SYS = 2'd1;
    localparam logic [1:0] SRC_TX  = 2'd2;
    localparam logic [1:0] SRC_RTC = 2'd3;
endpackage

// File: rtl/ref_tick_gen.sv
module ref_tick_gen
    import tod_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_ext,
    input  logic       ref_tx,
    input  logic       ref_rtc,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int NUM_ASYNC = 3;

    logic [NUM_ASYNC-1:0] raw;
    logic [NUM_ASYNC-1:0] rise;

    assign raw = {ref_rtc, ref_tx, ref_ext};

    for (genvar g = 0; g < NUM_ASYNC; g++) begin : g_sync
        logic [SYNC_STAGES:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-1:0], raw[g]};
        end
        assign rise[g] = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
    end

    always_comb begin
        unique case (sel)
            SRC_EXT: tick = rise[0];
            SRC_SYS: tick = 1'b1;
            SRC_TX:  tick = rise[1];
            SRC_RTC: tick = rise[2];
        endcase
    end
endmodule

// File: rtl/phase_acc.sv
module phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic [ACC_W-1:0] addend,
    output logic             step
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, addend};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            step  <= 1'b0;
        end else begin
            if (acc_en) acc_q <= sum[ACC_W-1:0];
            step <= acc_en & sum[ACC_W];
        end
    end

    // R6: without an accumulation no step can appear
    a_r6_no_step_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> !step);
    // R2/R6: accumulator frozen when not enabled
    a_r6_acc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> $stable(acc_q));
endmodule

// File: rtl/tod_time_reg.sv
module tod_time_reg #(
    parameter int TIME_W = 64,
    parameter int NS_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [NS_W-1:0]   period,
    input  logic              load_en,
    input  logic [TIME_W-1:0] load_val,
    output logic [TIME_W-1:0] time_q
);
    localparam int PAD_W = TIME_W - NS_W;

    logic [TIME_W-1:0] period_ext;
    assign period_ext = {{PAD_W{1'b0}}, period};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       time_q <= '0;
        else if (load_en) time_q <= load_val;
        else if (step)    time_q <= time_q + period_ext;
    end

    a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> time_q == $past(load_val));
    a_r3_step_adds_period: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_en) |=> time_q == $past(time_q) + $past(period_ext));
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load_en) |=> $stable(time_q));
endmodule

// File: rtl/tod_counter_top.sv
module tod_counter_top
    import tod_pkg::*;
#(
    parameter int ACC_W       = 32,
    parameter int TIME_W      = 64,
    parameter int NS_W        = 16,
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_CYC  = 4
) (
    input  logic              clk_sys,
    input  logic              rst_n,
    input  logic              ref_ext,
    input  logic              ref_tx,
    input  logic              ref_rtc,
    input  logic              src_wr,
    input  logic [1:0]        src_sel,
    input  logic              run_en,
    input  logic [ACC_W-1:0]  addend,
    input  logic [NS_W-1:0]   period_ns,
    input  logic              load_en,
    input  logic [TIME_W-1:0] load_time,
    output logic [TIME_W-1:0] time_ns
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(SETTLE_CYC - 1);

    tod_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]     src_q;
    logic           tick;
    logic           acc_en;
    logic           step;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:    if (run_en) state_d = ST_RUN;
            ST_RUN:    if (!run_en) state_d = ST_OFF;
            ST_SETTLE: if (cnt_q == '0) state_d = run_en ? ST_RUN : ST_OFF;
            default:   state_d = ST_OFF;
        endcase
        if (src_wr) state_d = ST_SETTLE;
    end

    // state register, settle countdown and source register
    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            src_q   <= SRC_SYS;
        end else begin
            state_q <= state_d;
            if (src_wr) begin
                src_q <= src_sel;
                cnt_q <= CNT_INIT;
            end else if (state_q == ST_SETTLE && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // outputs of the state machine
    always_comb begin
        acc_en = (state_q == ST_RUN) && tick;
    end

    ref_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk     (clk_sys),
        .rst_n   (rst_n),
        .ref_ext (ref_ext),
        .ref_tx  (ref_tx),
        .ref_rtc (ref_rtc),
        .sel     (src_q),
        .tick    (tick)
    );

    phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk    (clk_sys),
        .rst_n  (rst_n),
        .acc_en (acc_en),
        .addend (addend),
        .step   (step)
    );

    tod_time_reg #(.TIME_W(TIME_W), .NS_W(NS_W)) u_time (
        .clk      (clk_sys),
        .rst_n    (rst_n),
        .step     (step),
        .period   (period_ns),
        .load_en  (load_en),
        .load_val (load_time),
        .time_q   (time_ns)
    );

    a_r9_settle_quiet: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (state_q == ST_SETTLE) |-> !acc_en);
    a_r9_write_enters_settle: assert property (@(posedge clk_sys) disable iff (!rst_n)
        src_wr |=> (state_q == ST_SETTLE) && (cnt_q == CNT_INIT));
    a_r6_off_no_acc: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (state_q == ST_OFF) |-> !acc_en);
    a_r2_sys_every_cycle: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (state_q == ST_RUN && src_q == SRC_SYS) |-> acc_en);
endmodule

// File: tb/tb_tod_counter_top.sv
module tb_tod_counter_top;
    localparam int CLK_NS = 10;

    logic        clk_sys = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_ext = 1'b0, ref_tx = 1'b0, ref_rtc = 1'b0;
    logic        src_wr = 1'b0;
    logic [1:0]  src_sel = 2'd1;
    logic        run_en = 1'b0;
    logic [31:0] addend = '0;
    logic [15:0] period_ns = 16'd10;
    logic        load_en = 1'b0;
    logic [63:0] load_time = '0;
    logic [63:0] time_ns;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit model_on = 1'b1;
    string cur_req = "R1";
    logic [63:0] exp_q[$];

    tod_counter_top dut (
        .clk_sys(clk_sys), .rst_n(rst_n), .ref_ext(ref_ext), .ref_tx(ref_tx),
        .ref_rtc(ref_rtc), .src_wr(src_wr), .src_sel(src_sel), .run_en(run_en),
        .addend(addend), .period_ns(period_ns), .load_en(load_en),
        .load_time(load_time), .time_ns(time_ns)
    );

    always #(CLK_NS/2) clk_sys = ~clk_sys;
    always #50 ref_ext = ~ref_ext;
    always #35 ref_tx  = ~ref_tx;
    always #90 ref_rtc = ~ref_rtc;

    // reference model: pushes the expected time for each edge (R2 R3 R4 R5 R6 R7)
    logic [31:0] m_acc;
    logic        m_step, m_run;
    logic [63:0] m_time;
    always @(posedge clk_sys) begin
        logic [32:0] s;
        logic [63:0] nt;
        if (!rst_n) begin
            m_acc = '0; m_step = 1'b0; m_run = 1'b0; m_time = '0;
        end else if (model_on) begin
            s  = {1'b0, m_acc} + {1'b0, addend};
            nt = load_en ? load_time : (m_step ? m_time + 64'(period_ns) : m_time);
            if (m_run) begin
                m_acc  = s[31:0];
                m_step = s[32];
            end else begin
                m_step = 1'b0;
            end
            m_run  = run_en;
            m_time = nt;
            exp_q.push_back(nt);
        end
    end

    // monitor: compares the design against the queue away from the edge
    always @(negedge clk_sys) begin
        logic [63:0] e;
        while (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_cmp++;
            if (time_ns !== e) begin
                n_bad++;
                $display("FAIL %s: time_ns actual %0d expected %0d", cur_req, time_ns, e);
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic check_range(input string req, input logic [63:0] act,
                               input logic [63:0] lo, input logic [63:0] hi);
        n_cmp++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_sys);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // measure one asynchronous source: R8 R10
    task automatic measure_src(input string req, input logic [1:0] code,
                               input logic [63:0] lo, input logic [63:0] hi);
        src_sel = code; src_wr = 1'b1; addend = 32'h8000_0000;
        cycles(1);
        src_wr = 1'b0;
        cycles(12);
        load_en = 1'b1; load_time = '0;
        cycles(1);
        load_en = 1'b0;
        cycles(400);
        check_range(req, time_ns, lo, hi);
    endtask

    initial begin
        logic [63:0] t1, t2, t3;
        cycles(3);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", time_ns, 64'd0);
        cycles(5);
        // R1 R2 R3: default source is the system clock, nominal example addend
        cur_req = "R3";
        addend = 32'h9999_99A4; run_en = 1'b1;
        cycles(300);
        // R6: disabled, time holds
        cur_req = "R6";
        run_en = 1'b0;
        cycles(30);
        // R7: addend changes while running
        cur_req = "R7";
        run_en = 1'b1; addend = 32'h4000_0000;
        cycles(50);
        addend = 32'h1234_5678;
        cycles(7);
        addend = 32'hFFFF_FFFF;
        cycles(20);
        // R5: loads on cycles that also step
        cur_req = "R5";
        for (int k = 0; k < 6; k++) begin
            load_en = 1'b1; load_time = 64'd1_000_000 * (k + 1) + 64'(k);
            cycles(1);
            load_en = 1'b0;
            cycles(3 + k);
        end
        // R4: no carries, time holds
        cur_req = "R4";
        addend = '0;
        cycles(40);
        cur_req = "R2";
        period_ns = 16'd7; addend = 32'hC000_0000;
        cycles(60);
        model_on = 1'b0;
        cycles(2);

        // R9: source write freezes accumulation for the settle window
        period_ns = 16'd10; addend = 32'hFFFF_FFFF;
        cycles(5);
        src_sel = 2'd1; src_wr = 1'b1;
        cycles(1);
        src_wr = 1'b0;
        cycles(1);
        t1 = time_ns;
        cycles(4);
        t2 = time_ns;
        check("R9", t2, t1);
        cycles(2);
        t3 = time_ns;
        n_cmp++;
        if (t3 == t1) begin
            n_bad++;
            $display("FAIL R9: actual %0d expected a value other than %0d", t3, t1);
        end

        // R8 R10: asynchronous sources, each at its own rate
        measure_src("R8 ext(code 0)", 2'd0, 64'd180, 64'd220);
        measure_src("R10 tx(code 2)", 2'd2, 64'd270, 64'd300);
        measure_src("R10 rtc(code 3)", 2'd3, 64'd100, 64'd120);
        finish_run();
    end

    initial begin
        #(CLK_NS * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule